// File: doc/BRIEF.md
# Link Training Status Evaluator

This block turns the status bytes a display source reads back from a sink during link training into the decisions the training loop needs. For the active lanes (one, two or four), it flags whether every lane has finished clock recovery. It also flags whether channel equalization and inter-lane alignment are complete. For each lane, it also returns the voltage-swing and pre-emphasis levels the sink asks for.

It also times the pause between two status reads. On a start pulse it picks a wait from the sink's training-interval capability field, the sink's revision byte and the current training phase. It counts that wait in microsecond ticks derived from the core clock, then emits a one-cycle done pulse. Fetching the bytes over the auxiliary channel and programming the PHY happen outside this block.

Top module: `link_train_eval`

## Requirements
- R1: Lane n's 4-bit status nibble is in lane-status byte n/2, bits 3:0 for even n and bits 7:4 for odd n; the lane-status port carries byte k in bits 8k+7:8k.
- R2: `cr_done` is 1 exactly when every active lane's nibble has bit 0 (clock recovery locked) set.
- R3: `eq_done` is 1 exactly when bit 0 of `align_stat` is set and every active lane's nibble has bits 2:0 all set; whenever `eq_done` is 1, `cr_done` is also 1.
- R4: A lane is active when its index is below `lane_cnt`; the nibbles of inactive lanes have no effect on `cr_done` or `eq_done`.
- R5: For lane n, adjust byte n/2 (bits 8k+7:8k of `adjust_req`) holds swing in bits 1:0 and pre-emphasis in bits 3:2 for even n, and swing in bits 5:4 and pre-emphasis in bits 7:6 for odd n; these appear unshifted at `swing_lvl[2n+1:2n]` and `preemph_lvl[2n+1:2n]`.
- R6: The training interval is bits 6:0 of `train_cap`; bit 7 is ignored. `interval_warn` is 1 exactly when that interval exceeds 4.
- R7: With `poll_phase`=0 (clock recovery), the wait is 100 us when the interval is 0 or `sink_rev` is 0x14 or above, and otherwise interval x 4 ms.
- R8: With `poll_phase`=1 (equalization), the wait is 400 us when the interval is 0, and otherwise interval x 4 ms, whatever `sink_rev` holds.
- R9: When `poll_start` is sampled high, `poll_done` rises for exactly one cycle after the wait x TICK_CYCLES further rising edges. A new start while a wait is running discards the old wait and begins the new one.
- R10: During and after synchronous reset, with no start, `poll_done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_cnt | input | $clog2(MAX_LANES+1) | Number of active lanes |
| lane_stat | input | 8*((MAX_LANES+1)/2) | Packed per-lane status nibbles |
| align_stat | input | 8 | Alignment status byte; bit 0 = inter-lane aligned |
| adjust_req | input | 8*((MAX_LANES+1)/2) | Packed per-lane adjust requests |
| train_cap | input | 8 | Capability byte holding the training interval |
| sink_rev | input | 8 | Sink revision byte |
| poll_start | input | 1 | Start (or restart) the poll wait |
| poll_phase | input | 1 | 0 = clock-recovery wait, 1 = equalization wait |
| cr_done | output | 1 | All active lanes have clock recovery |
| eq_done | output | 1 | Equalization and alignment complete |
| swing_lvl | output | 2*MAX_LANES | Requested swing level per lane |
| preemph_lvl | output | 2*MAX_LANES | Requested pre-emphasis level per lane |
| interval_warn | output | 1 | Interval field above 4 |
| poll_done | output | 1 | One-cycle pulse at the end of the wait |

## Verification
The bench sweeps every combination of the three meaningful bits of four lane nibbles against each lane count and both alignment states. It puts stray bits in the reserved nibble bit and in the alignment byte. A design that picks the wrong nibble, ignores the lane count or tests the full alignment byte would then report training done too early or never. It runs every adjust-byte value, which catches swapped odd/even offsets, and every capability byte, which catches a missing bit-7 mask or an off-by-one warning threshold. The timer is measured edge by edge. The runs cover both phases, the revision override on each side of 0x14, a large interval and a restart mid-wait. A design that counts one tick short, lets the override leak into equalization or keeps the old wait after a restart shows a wrong edge count.

// File: rtl/lts_pkg.sv
// Shared constants for the link training status evaluator.
// Assumes lane nibbles and adjust bytes follow the standard bit layout.
package lts_pkg;
    localparam logic [3:0] NIB_CR_MASK      = 4'h1;
    localparam logic [3:0] NIB_EQ_MASK      = 4'h7;
    localparam logic [7:0] ALIGN_DONE_MASK  = 8'h01;
    localparam logic [7:0] INTERVAL_MASK    = 8'h7F;
    localparam logic [7:0] REV_FAST_CR      = 8'h14;
    localparam int unsigned INTERVAL_LIMIT  = 4;
    localparam int unsigned INTERVAL_MAX    = 127;
    localparam int unsigned CR_DEFAULT_US   = 100;
    localparam int unsigned EQ_DEFAULT_US   = 400;
    localparam int unsigned MS_PER_STEP     = 4;

    typedef enum logic {
        PHASE_CR = 1'b0,
        PHASE_EQ = 1'b1
    } phase_e;
endpackage

// File: rtl/lane_status_check.sv
// Decides clock-recovery and equalization completion over the active lanes.
// Assumes two lanes per status byte, even lane in the low nibble.
module lane_status_check
    import lts_pkg::*;
#(
    parameter int LANES = 4,
    parameter int CNT_W = 3,
    localparam int LB   = (LANES + 1) / 2
) (
    input  logic [CNT_W-1:0] lane_cnt,
    input  logic [8*LB-1:0]  lane_stat,
    input  logic [7:0]       align_stat,
    output logic             cr_done,
    output logic             eq_done
);
    logic [LANES-1:0] cr_ok;
    logic [LANES-1:0] eq_ok;

    // Per-lane pass flags; an inactive lane always passes.
    for (genvar n = 0; n < LANES; n++) begin : g_lane
        logic [3:0] nib;
        logic       active;
        assign nib      = lane_stat[8*(n/2) + 4*(n%2) +: 4];
        assign active   = (CNT_W'(n) < lane_cnt);
        assign cr_ok[n] = !active || ((nib & NIB_CR_MASK) == NIB_CR_MASK);
        assign eq_ok[n] = !active || ((nib & NIB_EQ_MASK) == NIB_EQ_MASK);
    end

    // Combine lanes; equalization also needs inter-lane alignment.
    assign cr_done = &cr_ok;
    assign eq_done = ((align_stat & ALIGN_DONE_MASK) != 8'h00) && (&eq_ok);
endmodule

// File: rtl/adjust_extract.sv
// Unpacks per-lane swing and pre-emphasis requests from the adjust bytes.
// Assumes two lanes per byte; levels are returned as plain 2-bit values.
module adjust_extract #(
    parameter int LANES = 4,
    localparam int LB   = (LANES + 1) / 2
) (
    input  logic [8*LB-1:0]    adjust_req,
    output logic [2*LANES-1:0] swing_lvl,
    output logic [2*LANES-1:0] preemph_lvl
);
    // Select the field offsets by lane parity.
    for (genvar n = 0; n < LANES; n++) begin : g_lane
        logic [7:0] adj_byte;
        assign adj_byte = adjust_req[8*(n/2) +: 8];
        if (n % 2 == 0) begin : g_even
            assign swing_lvl[2*n +: 2]   = adj_byte[1:0];
            assign preemph_lvl[2*n +: 2] = adj_byte[3:2];
        end else begin : g_odd
            assign swing_lvl[2*n +: 2]   = adj_byte[5:4];
            assign preemph_lvl[2*n +: 2] = adj_byte[7:6];
        end
    end
endmodule

// File: rtl/poll_timer.sv
// Wait timer between training status reads. Picks the wait from phase,
// interval and revision, counts it in microsecond ticks, then pulses done.
// Assumes TICK_CYCLES core cycles make one microsecond.
module poll_timer
    import lts_pkg::*;
#(
    parameter int TICK_CYCLES = 100,
    parameter int US_PER_MS   = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  phase_e     phase,
    input  logic [6:0] interval,
    input  logic [7:0] sink_rev,
    output logic       done
);
    localparam int unsigned STEP_US     = MS_PER_STEP * US_PER_MS;
    localparam int unsigned MAX_WAIT_US = INTERVAL_MAX * STEP_US;
    localparam int          W           = $clog2(MAX_WAIT_US + 1);
    localparam int          PW          = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [PW-1:0] PRE_LAST  = PW'(TICK_CYCLES - 1);

    logic [W-1:0]  wait_us;
    logic [W-1:0]  scaled_us;
    logic [W-1:0]  us_left;
    logic [PW-1:0] pre;
    logic          busy;

    // Choose the wait length for the requested phase.
    always_comb begin
        scaled_us = W'(interval) * W'(STEP_US);
        if (phase == PHASE_CR) begin
            wait_us = ((interval == 7'd0) || (sink_rev >= REV_FAST_CR)) ? W'(CR_DEFAULT_US) : scaled_us;
        end else begin
            wait_us = (interval == 7'd0) ? W'(EQ_DEFAULT_US) : scaled_us;
        end
    end

    // Prescale to microseconds, count down, pulse done on the last tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            pre     <= '0;
            us_left <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy    <= 1'b1;
                pre     <= '0;
                us_left <= wait_us;
            end else if (busy) begin
                if (pre == PRE_LAST) begin
                    pre     <= '0;
                    us_left <= us_left - W'(1);
                    if (us_left == W'(1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end else begin
                    pre <= pre + PW'(1);
                end
            end
        end
    end

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_start_arms_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && !done));
    assert_countdown_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> (us_left <= $past(us_left)));
endmodule

// File: rtl/link_train_eval.sv
// Top of the link training status evaluator: lane flags, adjust levels,
// interval warning and poll wait timer. Flags and levels are combinational.
module link_train_eval
    import lts_pkg::*;
#(
    parameter int MAX_LANES   = 4,
    parameter int TICK_CYCLES = 100,
    parameter int US_PER_MS   = 1000,
    localparam int CNT_W      = $clog2(MAX_LANES + 1),
    localparam int LB         = (MAX_LANES + 1) / 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CNT_W-1:0]       lane_cnt,
    input  logic [8*LB-1:0]        lane_stat,
    input  logic [7:0]             align_stat,
    input  logic [8*LB-1:0]        adjust_req,
    input  logic [7:0]             train_cap,
    input  logic [7:0]             sink_rev,
    input  logic                   poll_start,
    input  logic                   poll_phase,
    output logic                   cr_done,
    output logic                   eq_done,
    output logic [2*MAX_LANES-1:0] swing_lvl,
    output logic [2*MAX_LANES-1:0] preemph_lvl,
    output logic                   interval_warn,
    output logic                   poll_done
);
    logic [6:0] interval;

    // Mask the interval field and flag out-of-range values.
    assign interval      = 7'(train_cap & INTERVAL_MASK);
    assign interval_warn = ((train_cap & INTERVAL_MASK) > 8'(INTERVAL_LIMIT));

    lane_status_check #(.LANES(MAX_LANES), .CNT_W(CNT_W)) u_check (
        .lane_cnt   (lane_cnt),
        .lane_stat  (lane_stat),
        .align_stat (align_stat),
        .cr_done    (cr_done),
        .eq_done    (eq_done)
    );

    adjust_extract #(.LANES(MAX_LANES)) u_adjust (
        .adjust_req  (adjust_req),
        .swing_lvl   (swing_lvl),
        .preemph_lvl (preemph_lvl)
    );

    poll_timer #(.TICK_CYCLES(TICK_CYCLES), .US_PER_MS(US_PER_MS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (poll_start),
        .phase    (phase_e'(poll_phase)),
        .interval (interval),
        .sink_rev (sink_rev),
        .done     (poll_done)
    );

    assert_eq_implies_cr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eq_done |-> cr_done);
endmodule

// File: tb/link_train_eval_test.sv
`timescale 1ns/1ps
module link_train_eval_test;
    localparam int L    = 4;
    localparam int CW   = 3;
    localparam int LB   = 2;
    localparam int TICK = 2;
    localparam int UPM  = 10;
    localparam int STEP = 4 * UPM;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CW-1:0]     lane_cnt = '0;
    logic [8*LB-1:0]   lane_stat = '0;
    logic [7:0]        align_stat = '0;
    logic [8*LB-1:0]   adjust_req = '0;
    logic [7:0]        train_cap = '0;
    logic [7:0]        sink_rev = '0;
    logic              poll_start = 1'b0;
    logic              poll_phase = 1'b0;
    logic              cr_done, eq_done, interval_warn, poll_done;
    logic [2*L-1:0]    swing_lvl, preemph_lvl;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    link_train_eval #(.MAX_LANES(L), .TICK_CYCLES(TICK), .US_PER_MS(UPM)) uut (
        .clk(clk), .rst_n(rst_n), .lane_cnt(lane_cnt), .lane_stat(lane_stat),
        .align_stat(align_stat), .adjust_req(adjust_req), .train_cap(train_cap),
        .sink_rev(sink_rev), .poll_start(poll_start), .poll_phase(poll_phase),
        .cr_done(cr_done), .eq_done(eq_done), .swing_lvl(swing_lvl),
        .preemph_lvl(preemph_lvl), .interval_warn(interval_warn), .poll_done(poll_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a miscompare and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected 0", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // Start a wait and count rising edges until the done pulse (R9).
    task automatic run_wait(input logic ph, input logic [7:0] cap, input logic [7:0] rev,
                            input int exp_us, input string req);
        int cnt;
        int exp_cyc;
        cnt = 0;
        exp_cyc = exp_us * TICK;
        @(negedge clk);
        poll_phase = ph; train_cap = cap; sink_rev = rev; poll_start = 1'b1;
        @(negedge clk);
        poll_start = 1'b0;
        while (cnt <= exp_cyc + 20) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (poll_done) break;
        end
        check(cnt == exp_cyc, req, cnt, exp_cyc);
        @(negedge clk);
        check(poll_done == 1'b0, "R9 pulse width", int'(poll_done), 0);
    endtask

    initial begin
        logic [3:0] nib;
        bit exp_cr;
        bit exp_eq;
        int sh;
        logic [7:0] ab;

        // R10: reset state.
        repeat (3) @(negedge clk);
        check(poll_done == 1'b0, "R10 in reset", int'(poll_done), 0);
        rst_n = 1'b1;
        repeat (5) begin
            @(negedge clk);
            check(poll_done == 1'b0, "R10 idle after reset", int'(poll_done), 0);
        end

        // R1 R2 R3 R4: sweep the low three bits of every nibble, all counts, both alignments.
        for (int cnt = 1; cnt <= L; cnt++) begin
            for (int al = 0; al < 2; al++) begin
                for (int i = 0; i < 4096; i++) begin
                    logic [15:0] ls;
                    for (int n = 0; n < L; n++) begin
                        ls[8*(n/2) + 4*(n%2) +: 3] = 3'((i >> (3*n)) & 7);
                        ls[8*(n/2) + 4*(n%2) + 3]  = 1'((i >> n) & 1);
                    end
                    lane_cnt   = CW'(cnt);
                    lane_stat  = ls;
                    align_stat = (al != 0) ? 8'h81 : 8'hFE;
                    exp_cr = 1'b1;
                    exp_eq = (al != 0);
                    for (int n = 0; n < cnt; n++) begin
                        nib = ls[8*(n/2) + 4*(n%2) +: 4];
                        if (nib[0] == 1'b0) exp_cr = 1'b0;
                        if (nib[2:0] != 3'b111) exp_eq = 1'b0;
                    end
                    #1;
                    check(cr_done == exp_cr, "R2 clock recovery flag", int'(cr_done), int'(exp_cr));
                    check(eq_done == exp_eq, "R3 equalization flag", int'(eq_done), int'(exp_eq));
                end
            end
        end

        // R4: inactive lanes carry failing nibbles yet do not matter.
        lane_cnt = 3'd1; lane_stat = 16'h0007; align_stat = 8'h01; #1;
        check(cr_done && eq_done, "R4 one lane", int'({cr_done, eq_done}), 3);
        lane_cnt = 3'd2; lane_stat = 16'h0077; #1;
        check(cr_done && eq_done, "R4 two lanes", int'({cr_done, eq_done}), 3);
        lane_cnt = 3'd4; #1;
        check(!cr_done && !eq_done, "R4 four lanes", int'({cr_done, eq_done}), 0);

        // R5: every adjust byte value, the other byte inverted.
        for (int v = 0; v < 256; v++) begin
            adjust_req = {8'(~v), 8'(v)};
            #1;
            for (int n = 0; n < L; n++) begin
                ab = adjust_req[8*(n/2) +: 8];
                sh = (n % 2 == 1) ? 4 : 0;
                check(swing_lvl[2*n +: 2] == 2'((ab >> sh) & 3), "R5 swing",
                      int'(swing_lvl[2*n +: 2]), int'((ab >> sh) & 3));
                check(preemph_lvl[2*n +: 2] == 2'((ab >> (sh + 2)) & 3), "R5 pre-emphasis",
                      int'(preemph_lvl[2*n +: 2]), int'((ab >> (sh + 2)) & 3));
            end
        end

        // R6: every capability byte value.
        for (int c = 0; c < 256; c++) begin
            train_cap = 8'(c);
            #1;
            check(interval_warn == ((c & 8'h7F) > 4), "R6 interval warning",
                  int'(interval_warn), int'((c & 8'h7F) > 4));
        end

        // R7: clock-recovery waits.
        run_wait(1'b0, 8'h00, 8'h12, 100,      "R7 zero interval");
        run_wait(1'b0, 8'h03, 8'h12, 3 * STEP, "R7 interval 3 old revision");
        run_wait(1'b0, 8'h03, 8'h14, 100,      "R7 revision override at 0x14");
        run_wait(1'b0, 8'h02, 8'h20, 100,      "R7 revision override above");
        run_wait(1'b0, 8'h82, 8'h13, 2 * STEP, "R6 bit 7 ignored in CR wait");
        // R8: equalization waits.
        run_wait(1'b1, 8'h00, 8'h12, 400,      "R8 zero interval");
        run_wait(1'b1, 8'h03, 8'h14, 3 * STEP, "R8 no revision override");
        run_wait(1'b1, 8'h05, 8'h10, 5 * STEP, "R8 out-of-range interval");
        run_wait(1'b1, 8'h7F, 8'h00, 127 * STEP, "R8 largest interval");

        // R9: restart mid-wait takes the new wait only.
        @(negedge clk);
        poll_phase = 1'b1; train_cap = 8'h00; poll_start = 1'b1;
        @(negedge clk);
        poll_start = 1'b0;
        repeat (50) @(negedge clk);
        check(poll_done == 1'b0, "R9 no early done", int'(poll_done), 0);
        run_wait(1'b1, 8'h01, 8'h00, STEP, "R9 restart");
        repeat (900) begin
            @(negedge clk);
            check(poll_done == 1'b0, "R9 old wait discarded", int'(poll_done), 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule